// File: doc/BRIEF.md
# Tiled Address Bit-6 Swizzler

This block adjusts bit 6 of a byte address so that a tiled surface lands on the correct channel of a memory system that interleaves two channels. Bit 6 is replaced by itself XORed with a set of higher address bits. The set depends on two things: the memory-channel configuration and whether the surface is tiled along X or along Y. All other address bits leave the block as they arrived.

A configuration decoder chooses one swizzle mode for X tiling and one for Y tiling. A select input picks one of two decoders:

- **Control-word decoder.** It uses an addressing-mode field, a channel-XOR disable, a channel-XOR source select and a read-failure flag.
- **Rank-size decoder.** It compares the populated size reported by each channel.

Each request carries an address, a tiling kind and a valid strobe. One clock later the block returns the rewritten address, the 3-bit mode code it applied and an untileable flag. The configuration inputs are expected to be quasi-static. They are sampled in the same cycle as the request.

Top module: `swz_bit6_top`

## Requirements
- R1: Tiling code 0 (linear) and code 3 (reserved) return the address unchanged with mode_o = 0, whatever the configuration.
- R2: Control path (cfg_sel_i=0), chan_mode_i=2 (dual interleaved), xor_off_i=1: X tiling (code 1) gives bit6 ^ bit9 ^ bit10 with mode 2. Y tiling (code 2) gives bit6 ^ bit9 with mode 1.
- R3: Control path, chan_mode_i=2, xor_off_i=0, xor_hi_i=0 (low source): bit 11 joins the set. X gives mode 4 (bits 9,10,11). Y gives mode 3 (bits 9,11).
- R4: Control path, chan_mode_i=2, xor_off_i=0, xor_hi_i=1 (high source): bit 17 joins the set. X gives mode 6 (bits 9,10,17). Y gives mode 5 (bits 9,17).
- R5: Control path with chan_mode_i of 0 (single), 1 (dual asymmetric) or 3 (reserved): tiled requests get mode 0 and an unchanged address.
- R6: Control path with rd_fail_i=1: tiled requests get mode 7, untileable_o=1 and an unchanged address. This holds regardless of the other control inputs.
- R7: Rank path (cfg_sel_i=1): if rank0_i equals rank1_i, tiled requests get the same result as R2. Otherwise they get mode 0 and an unchanged address. In this path chan_mode_i, xor_off_i, xor_hi_i and rd_fail_i have no effect.
- R8: Every address bit other than bit 6 leaves the block unchanged.
- R9: Outputs are registered one cycle after the request is sampled, and valid_o repeats valid_i from one cycle earlier. untileable_o is 1 exactly when mode_o is 7.
- R10: During reset, valid_o, addr_o, mode_o and untileable_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Request strobe |
| addr_i | input | ADDR_W | Byte address |
| tile_i | input | 2 | Tiling kind: 0 linear, 1 X, 2 Y, 3 reserved |
| cfg_sel_i | input | 1 | Decoder select: 0 control word, 1 rank-size compare |
| chan_mode_i | input | 2 | Addressing mode: 0 single, 1 dual asymmetric, 2 dual interleaved, 3 reserved |
| xor_off_i | input | 1 | Channel-XOR disable |
| xor_hi_i | input | 1 | Channel-XOR source: 0 bit 11, 1 bit 17 |
| rd_fail_i | input | 1 | Configuration read returned all ones |
| rank0_i | input | SIZE_W | Populated size of channel 0 |
| rank1_i | input | SIZE_W | Populated size of channel 1 |
| valid_o | output | 1 | Result strobe |
| addr_o | output | ADDR_W | Swizzled address |
| mode_o | output | 3 | Applied mode code |
| untileable_o | output | 1 | Tiled request cannot be served |

## Verification
The assertions assume that valid_i is held low while reset is asserted. This matters because the first post-reset comparison of a result against the previous cycle's request relies on it. The assertions also assume that tile_i and the configuration inputs are driven to known values in every cycle.

The stimulus changes inputs only on the falling clock edge and keeps valid_i at zero throughout reset. It mixes fully random configurations with directed ones that pin each decoder branch. Addresses are random, with bits 9, 10, 11 and 17 also forced to every combination.

// File: rtl/swz_pkg.sv
package swz_pkg;
  typedef enum logic [2:0] {
    SWZ_NONE    = 3'd0,
    SWZ_9       = 3'd1,
    SWZ_9_10    = 3'd2,
    SWZ_9_11    = 3'd3,
    SWZ_9_10_11 = 3'd4,
    SWZ_9_17    = 3'd5,
    SWZ_9_10_17 = 3'd6,
    SWZ_UNK     = 3'd7
  } swz_mode_e;

  typedef enum logic [1:0] {
    TILE_LIN = 2'd0,
    TILE_X   = 2'd1,
    TILE_Y   = 2'd2,
    TILE_RSV = 2'd3
  } tile_e;

  typedef enum logic [1:0] {
    CH_SINGLE = 2'd0,
    CH_ASYM   = 2'd1,
    CH_INTLV  = 2'd2,
    CH_RSV    = 2'd3
  } chan_e;

  localparam int TGT_BIT = 6;
  localparam int NTAP    = 4;
  // tap order: 9, 10, 11, 17
  localparam int TAP_POS [NTAP] = '{9, 10, 11, 17};
  localparam int MIN_ADDR_W = 18;
endpackage

// File: rtl/swz_cfg_decode.sv
module swz_cfg_decode
  import swz_pkg::*;
#(
  parameter int SIZE_W = 16
) (
  input  logic              cfg_sel_i,
  input  logic [1:0]        chan_mode_i,
  input  logic              xor_off_i,
  input  logic              xor_hi_i,
  input  logic              rd_fail_i,
  input  logic [SIZE_W-1:0] rank0_i,
  input  logic [SIZE_W-1:0] rank1_i,
  output swz_mode_e         mode_x_o,
  output swz_mode_e         mode_y_o
);
  swz_mode_e ctl_x, ctl_y, rnk_x, rnk_y;
  chan_e     chan;

  assign chan = chan_e'(chan_mode_i);

  always_comb begin
    ctl_x = SWZ_NONE;
    ctl_y = SWZ_NONE;
    if (chan == CH_INTLV) begin
      if (xor_off_i) begin
        ctl_x = SWZ_9_10;
        ctl_y = SWZ_9;
      end else if (!xor_hi_i) begin
        ctl_x = SWZ_9_10_11;
        ctl_y = SWZ_9_11;
      end else begin
        ctl_x = SWZ_9_10_17;
        ctl_y = SWZ_9_17;
      end
    end
    // failed read overrides the whole control word
    if (rd_fail_i) begin
      ctl_x = SWZ_UNK;
      ctl_y = SWZ_UNK;
    end
  end

  always_comb begin
    if (rank0_i == rank1_i) begin
      rnk_x = SWZ_9_10;
      rnk_y = SWZ_9;
    end else begin
      rnk_x = SWZ_NONE;
      rnk_y = SWZ_NONE;
    end
  end

  assign mode_x_o = cfg_sel_i ? rnk_x : ctl_x;
  assign mode_y_o = cfg_sel_i ? rnk_y : ctl_y;
endmodule

// File: rtl/swz_mode_pick.sv
module swz_mode_pick
  import swz_pkg::*;
(
  input  logic [1:0] tile_i,
  input  swz_mode_e  mode_x_i,
  input  swz_mode_e  mode_y_i,
  output swz_mode_e  mode_o,
  output logic       untile_o
);
  always_comb begin
    unique case (tile_e'(tile_i))
      TILE_X:  mode_o = mode_x_i;
      TILE_Y:  mode_o = mode_y_i;
      default: mode_o = SWZ_NONE;
    endcase
  end

  assign untile_o = (mode_o == SWZ_UNK);
endmodule

// File: rtl/swz_xor_unit.sv
module swz_xor_unit
  import swz_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  swz_mode_e         mode_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [NTAP-1:0] tap_en;
  logic [NTAP-1:0] tap_bit;

  always_comb begin
    unique case (mode_i)
      SWZ_9:       tap_en = 4'b0001;
      SWZ_9_10:    tap_en = 4'b0011;
      SWZ_9_11:    tap_en = 4'b0101;
      SWZ_9_10_11: tap_en = 4'b0111;
      SWZ_9_17:    tap_en = 4'b1001;
      SWZ_9_10_17: tap_en = 4'b1011;
      default:     tap_en = 4'b0000;
    endcase
  end

  for (genvar t = 0; t < NTAP; t++) begin : g_tap
    assign tap_bit[t] = tap_en[t] & addr_i[TAP_POS[t]];
  end

  always_comb begin
    addr_o          = addr_i;
    addr_o[TGT_BIT] = addr_i[TGT_BIT] ^ (^tap_bit);
  end
endmodule

// File: rtl/swz_bit6_top.sv
module swz_bit6_top
  import swz_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        tile_i,
  input  logic              cfg_sel_i,
  input  logic [1:0]        chan_mode_i,
  input  logic              xor_off_i,
  input  logic              xor_hi_i,
  input  logic              rd_fail_i,
  input  logic [SIZE_W-1:0] rank0_i,
  input  logic [SIZE_W-1:0] rank1_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [2:0]        mode_o,
  output logic              untileable_o
);
  localparam logic [ADDR_W-1:0] KEEP_MASK = ~(ADDR_W'(1) << TGT_BIT);

  initial begin
    if (ADDR_W < MIN_ADDR_W) $error("ADDR_W too small for tap bit 17");
  end

  swz_mode_e mode_x, mode_y, mode_sel;
  logic      untile_c;
  logic [ADDR_W-1:0] addr_c;

  swz_cfg_decode #(.SIZE_W(SIZE_W)) cfg_dec_i (
    .cfg_sel_i   (cfg_sel_i),
    .chan_mode_i (chan_mode_i),
    .xor_off_i   (xor_off_i),
    .xor_hi_i    (xor_hi_i),
    .rd_fail_i   (rd_fail_i),
    .rank0_i     (rank0_i),
    .rank1_i     (rank1_i),
    .mode_x_o    (mode_x),
    .mode_y_o    (mode_y)
  );

  swz_mode_pick pick_i (
    .tile_i   (tile_i),
    .mode_x_i (mode_x),
    .mode_y_i (mode_y),
    .mode_o   (mode_sel),
    .untile_o (untile_c)
  );

  swz_xor_unit #(.ADDR_W(ADDR_W)) xor_i (
    .addr_i (addr_i),
    .mode_i (mode_sel),
    .addr_o (addr_c)
  );

  logic              valid_q;
  logic [ADDR_W-1:0] addr_q;
  logic [2:0]        mode_q;
  logic              untile_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q  <= 1'b0;
      addr_q   <= '0;
      mode_q   <= 3'd0;
      untile_q <= 1'b0;
    end else begin
      valid_q  <= valid_i;
      addr_q   <= addr_c;
      mode_q   <= mode_sel;
      untile_q <= untile_c;
    end
  end

  assign valid_o      = valid_q;
  assign addr_o       = addr_q;
  assign mode_o       = mode_q;
  assign untileable_o = untile_q;

  // R8
  keep_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ((addr_o & KEEP_MASK) == ($past(addr_i) & KEEP_MASK)));

  // R1
  linear_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && ($past(tile_i) == TILE_LIN || $past(tile_i) == TILE_RSV))
      |-> (addr_o == $past(addr_i) && mode_o == 3'd0));

  // R6
  unknown_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && untileable_o) |-> (mode_o == 3'd7 && addr_o == $past(addr_i)));

  // R5
  none_bit6_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && mode_o == 3'd0) |-> (addr_o[TGT_BIT] == $past(addr_i[TGT_BIT])));

  // R9
  untile_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    untileable_o == (mode_o == 3'd7));
endmodule

// File: tb/swz_bit6_top_tb_top.sv
module swz_bit6_top_tb_top;
  localparam int ADDR_W = 32;
  localparam int SIZE_W = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              valid_i = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [1:0]        tile_i = '0;
  logic              cfg_sel_i = 1'b0;
  logic [1:0]        chan_mode_i = '0;
  logic              xor_off_i = 1'b0;
  logic              xor_hi_i = 1'b0;
  logic              rd_fail_i = 1'b0;
  logic [SIZE_W-1:0] rank0_i = '0;
  logic [SIZE_W-1:0] rank1_i = '0;
  logic              valid_o;
  logic [ADDR_W-1:0] addr_o;
  logic [2:0]        mode_o;
  logic              untileable_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  swz_bit6_top #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .addr_i(addr_i),
    .tile_i(tile_i), .cfg_sel_i(cfg_sel_i), .chan_mode_i(chan_mode_i),
    .xor_off_i(xor_off_i), .xor_hi_i(xor_hi_i), .rd_fail_i(rd_fail_i),
    .rank0_i(rank0_i), .rank1_i(rank1_i), .valid_o(valid_o),
    .addr_o(addr_o), .mode_o(mode_o), .untileable_o(untileable_o)
  );

  function automatic logic [2:0] exp_mode(logic [1:0] t, logic sel, logic [1:0] cm,
                                           logic off, logic hi, logic fail,
                                           logic [SIZE_W-1:0] r0, logic [SIZE_W-1:0] r1);
    if (t == 2'd0 || t == 2'd3) return 3'd0;
    if (sel) return (r0 == r1) ? ((t == 2'd1) ? 3'd2 : 3'd1) : 3'd0;
    if (fail) return 3'd7;
    if (cm != 2'd2) return 3'd0;
    if (off) return (t == 2'd1) ? 3'd2 : 3'd1;
    if (!hi) return (t == 2'd1) ? 3'd4 : 3'd3;
    return (t == 2'd1) ? 3'd6 : 3'd5;
  endfunction

  function automatic logic [ADDR_W-1:0] exp_addr(logic [ADDR_W-1:0] a, logic [2:0] m);
    logic x;
    logic [ADDR_W-1:0] r;
    case (m)
      3'd1: x = a[9];
      3'd2: x = a[9] ^ a[10];
      3'd3: x = a[9] ^ a[11];
      3'd4: x = a[9] ^ a[10] ^ a[11];
      3'd5: x = a[9] ^ a[17];
      3'd6: x = a[9] ^ a[10] ^ a[17];
      default: x = 1'b0;
    endcase
    r = a;
    r[6] = a[6] ^ x;
    return r;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive at negedge, check after the next rising edge
  task automatic req(string tag, logic [ADDR_W-1:0] a, logic [1:0] t, logic sel,
                     logic [1:0] cm, logic off, logic hi, logic fail,
                     logic [SIZE_W-1:0] r0, logic [SIZE_W-1:0] r1);
    logic [2:0] em;
    em = exp_mode(t, sel, cm, off, hi, fail, r0, r1);
    valid_i = 1'b1; addr_i = a; tile_i = t; cfg_sel_i = sel; chan_mode_i = cm;
    xor_off_i = off; xor_hi_i = hi; rd_fail_i = fail; rank0_i = r0; rank1_i = r1;
    @(posedge clk);
    @(negedge clk);
    valid_i = 1'b0;
    chk({tag, " R9 valid"}, 64'(valid_o), 64'd1);
    chk({tag, " addr"}, 64'(addr_o), 64'(exp_addr(a, em)));
    chk({tag, " mode"}, 64'(mode_o), 64'(em));
    chk({tag, " R9 untile"}, 64'(untileable_o), 64'(em == 3'd7));
    chk({tag, " R8 upper"}, 64'(addr_o & ~32'h40), 64'(a & ~32'h40));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int unused;
    unused = $urandom(32'h5eed_b16);
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 valid", 64'(valid_o), 64'd0);
    chk("R10 addr", 64'(addr_o), 64'd0);
    chk("R10 mode", 64'(mode_o), 64'd0);
    chk("R10 untile", 64'(untileable_o), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 idle valid", 64'(valid_o), 64'd0);

    // directed: every combo of tap bits 9,10,11,17 and bit 6
    for (int k = 0; k < 32; k++) begin
      logic [ADDR_W-1:0] a;
      a = 32'hA5A5_0000;
      a[6] = k[0]; a[9] = k[1]; a[10] = k[2]; a[11] = k[3]; a[17] = k[4];
      req("R1 lin",  a, 2'd0, 1'b0, 2'd2, 1'b0, 1'b1, 1'b0, 16'd1, 16'd1);
      req("R1 rsv",  a, 2'd3, 1'b1, 2'd2, 1'b0, 1'b1, 1'b0, 16'd1, 16'd1);
      req("R2 x",    a, 2'd1, 1'b0, 2'd2, 1'b1, 1'b1, 1'b0, 16'd0, 16'd5);
      req("R2 y",    a, 2'd2, 1'b0, 2'd2, 1'b1, 1'b0, 1'b0, 16'd0, 16'd5);
      req("R3 x",    a, 2'd1, 1'b0, 2'd2, 1'b0, 1'b0, 1'b0, 16'd0, 16'd0);
      req("R3 y",    a, 2'd2, 1'b0, 2'd2, 1'b0, 1'b0, 1'b0, 16'd0, 16'd0);
      req("R4 x",    a, 2'd1, 1'b0, 2'd2, 1'b0, 1'b1, 1'b0, 16'd0, 16'd0);
      req("R4 y",    a, 2'd2, 1'b0, 2'd2, 1'b0, 1'b1, 1'b0, 16'd0, 16'd0);
      req("R5 sgl",  a, 2'd1, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0, 16'd0, 16'd0);
      req("R5 asym", a, 2'd2, 1'b0, 2'd1, 1'b0, 1'b0, 1'b0, 16'd0, 16'd0);
      req("R5 rsv",  a, 2'd1, 1'b0, 2'd3, 1'b1, 1'b0, 1'b0, 16'd0, 16'd0);
      req("R6 fail", a, 2'd1, 1'b0, 2'd2, 1'b0, 1'b1, 1'b1, 16'd0, 16'd0);
      req("R6 failsgl", a, 2'd2, 1'b0, 2'd0, 1'b1, 1'b0, 1'b1, 16'd0, 16'd0);
      req("R7 eq x", a, 2'd1, 1'b1, 2'd0, 1'b0, 1'b1, 1'b1, 16'h1234, 16'h1234);
      req("R7 eq y", a, 2'd2, 1'b1, 2'd1, 1'b0, 1'b1, 1'b1, 16'h0400, 16'h0400);
      req("R7 ne",   a, 2'd1, 1'b1, 2'd2, 1'b0, 1'b1, 1'b0, 16'h0400, 16'h0200);
    end

    // random mix
    for (int n = 0; n < 2000; n++) begin
      logic [SIZE_W-1:0] r0, r1;
      r0 = SIZE_W'($urandom_range(0, 7));
      r1 = ($urandom_range(0, 1) == 0) ? r0 : SIZE_W'($urandom_range(0, 7));
      req("R8 rnd", ADDR_W'($urandom), 2'($urandom_range(0, 3)),
          1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)),
          1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
          ($urandom_range(0, 7) == 0), r0, r1);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule